// File: doc/BRIEF.md
# Physical Memory Type Resolver

This block maps a physical address to the cache memory type that governs it. Two sets of programmable state decide the answer. A table of 88 fixed entries covers the first megabyte in three granularities. A bank of variable ranges, each defined by a base and a mask, covers the rest. A control word holds the fallback type and two enables: a global enable and a fixed-table enable.

Configuration software loads all state through a single write port. Lookups then arrive one address per cycle, and each result comes out of a register on the next clock edge. The fixed table has priority inside the first megabyte when it is enabled. When more than one variable range covers an address, the result follows a precedence rule that favours the less permissive type. If the global enable is clear, every lookup reports the invalid code.

Top module: `memtype_resolver`

## Requirements
- R1: For an address below 0x80000, the fixed-table index is address>>16 (entries 0..7, 64 KB each).
- R2: For an address from 0x80000 to 0xBFFFF, the index is 8 + ((address−0x80000)>>14) (entries 8..23, 16 KB each).
- R3: For an address from 0xC0000 to 0xFFFFF, the index is 24 + ((address−0xC0000)>>12) (entries 24..87, 4 KB each).
- R4: The fixed table decides the type only when all of these hold: the address is below 0x100000, the table is present (HAS_FIXED=1), and the fixed enable is set. In that case it overrides every variable range. Otherwise, low addresses go through the variable ranges and the default type.
- R5: A variable range matches when address bits [ADDR_W-1:12] AND mask equal base AND mask, and only if its valid bit (bit 11 of its mask word) is set. Its type is bits [7:0] of its base word. When all hits carry the same type, that type is the result.
- R6: If any matching variable range has type UC (0x00), the result is UC.
- R7: If the hits disagree and their types are only WB (0x06) and WT (0x04), the result is WT. Any other disagreement gives UC.
- R8: When no variable range matches (and the fixed table is not used), the result is the default type in bits [7:0] of the control word.
- R9: The control word's bit 11 is the global enable and bit 10 is the fixed enable. With the global enable clear, the result is 0xFF and rsp_invalid is 1.
- R10: A request in the cycle of rising edge k is answered with rsp_valid=1 after edge k. A configuration write accepted at edge k affects a request accepted at edge k+1.
- R11: After reset, rsp_valid=0, rsp_invalid=1, rsp_type=0xFF, and all state is zero, so both enables are clear.
- R12: The write port uses cfg_sel to pick the target: 0 selects the control word (cfg_wdata[11:0]), 1 selects fixed entry cfg_idx (cfg_wdata[7:0]), 2 selects variable base word cfg_idx, and 3 selects variable mask word cfg_idx. A write with an index beyond the addressed structure changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 fixed entry, 2 range base, 3 range mask |
| cfg_idx | input | IDX_W | Entry or range index |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Physical address to resolve |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type |
| rsp_invalid | output | 1 | High when resolution is globally disabled |

## Verification
The bench builds the block with ADDR_W=24 and NUM_VAR=4. This makes the whole 16 MiB space 4096 pages, so every page can be swept under each configuration. The first megabyte is only 256 pages, so all 88 fixed entries and every region boundary are visited. Four overlapping ranges are enough to produce single hits, same-type overlaps, WB/WT merges, UC dominance, invalid-bit suppression and default fallthrough. The expected results come from an arithmetic model that the bench evaluates for each page.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
   localparam logic [7:0] TYPE_UC      = 8'h00;
   localparam logic [7:0] TYPE_WC      = 8'h01;
   localparam logic [7:0] TYPE_WT      = 8'h04;
   localparam logic [7:0] TYPE_WP      = 8'h05;
   localparam logic [7:0] TYPE_WB      = 8'h06;
   localparam logic [7:0] TYPE_INVALID = 8'hFF;

   localparam int FIX_ENTRIES = 88;
   localparam int PAGE_LSB    = 12;
   localparam int LOW_MB_BITS = 20;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_FIXED = 2'd1,
      SEL_BASE  = 2'd2,
      SEL_MASK  = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/mtr_fixed_table.sv
module mtr_fixed_table
   import memtype_pkg::*;
#(
   parameter int IDX_W = 8
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [7:0]             wr_type,
   input  logic [LOW_MB_BITS-1:0] lk_addr,
   output logic [7:0]             lk_type
);
   localparam int ENT_W = $clog2(FIX_ENTRIES);

   logic [7:0]       ent_q [FIX_ENTRIES];
   logic [ENT_W-1:0] rd_idx;

   // region select from the top address bits of the low megabyte
   always_comb begin
      if (!lk_addr[19])
         rd_idx = ENT_W'(lk_addr[18:16]);
      else if (!lk_addr[18])
         rd_idx = ENT_W'(8) + ENT_W'(lk_addr[17:14]);
      else
         rd_idx = ENT_W'(24) + ENT_W'(lk_addr[17:12]);
   end

   assign lk_type = ent_q[rd_idx];

   for (genvar e = 0; e < FIX_ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q[e] <= '0;
         else if (wr_en && wr_idx == IDX_W'(e))
            ent_q[e] <= wr_type;
      end
   end
endmodule

// File: rtl/mtr_var_bank.sv
module mtr_var_bank
   import memtype_pkg::*;
#(
   parameter int ADDR_W  = 36,
   parameter int NUM_VAR = 8,
   parameter int IDX_W   = 8
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_base,
   input  logic                      wr_mask,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [ADDR_W-1:0]         wr_data,
   input  logic [ADDR_W-1:0]         lk_addr,
   output logic [NUM_VAR-1:0]        hit,
   output logic [NUM_VAR-1:0][7:0]   hit_type
);
   localparam int PG_W = ADDR_W - PAGE_LSB;

   for (genvar r = 0; r < NUM_VAR; r++) begin : g_rng
      logic [PG_W-1:0] base_q;
      logic [PG_W-1:0] mask_q;
      logic [7:0]      type_q;
      logic            vld_q;
      logic            sel;

      assign sel = (wr_idx == IDX_W'(r));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            type_q <= '0;
         end else if (wr_base && sel) begin
            base_q <= wr_data[ADDR_W-1:PAGE_LSB];
            type_q <= wr_data[7:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q <= '0;
            vld_q  <= 1'b0;
         end else if (wr_mask && sel) begin
            mask_q <= wr_data[ADDR_W-1:PAGE_LSB];
            vld_q  <= wr_data[11];
         end
      end

      assign hit[r] = vld_q &&
         ((lk_addr[ADDR_W-1:PAGE_LSB] & mask_q) == (base_q & mask_q));
      assign hit_type[r] = type_q;
   end
endmodule

// File: rtl/mtr_merge.sv
module mtr_merge
   import memtype_pkg::*;
#(
   parameter int NUM_VAR = 8
)(
   input  logic [NUM_VAR-1:0]      hit,
   input  logic [NUM_VAR-1:0][7:0] hit_type,
   output logic                    any_hit,
   output logic [7:0]              merged
);
   logic [7:0] first_t;
   logic       differ;
   logic       only_wbwt;

   always_comb begin
      first_t = TYPE_UC;
      for (int r = NUM_VAR - 1; r >= 0; r--)
         if (hit[r]) first_t = hit_type[r];
   end

   always_comb begin
      differ    = 1'b0;
      only_wbwt = 1'b1;
      for (int r = 0; r < NUM_VAR; r++) begin
         if (hit[r]) begin
            if (hit_type[r] != first_t) differ = 1'b1;
            if (hit_type[r] != TYPE_WB && hit_type[r] != TYPE_WT) only_wbwt = 1'b0;
         end
      end
   end

   assign any_hit = |hit;

   // agreement keeps the common type; a WB/WT-only mix gives WT; the rest give UC
   always_comb begin
      if (!differ)
         merged = first_t;
      else if (only_wbwt)
         merged = TYPE_WT;
      else
         merged = TYPE_UC;
   end
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
   import memtype_pkg::*;
#(
   parameter int ADDR_W    = 36,
   parameter int NUM_VAR   = 8,
   parameter int IDX_W     = 8,
   parameter bit HAS_FIXED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [7:0]        rsp_type,
   output logic              rsp_invalid
);
   localparam int IDX_SPAN = (NUM_VAR > FIX_ENTRIES) ? NUM_VAR : FIX_ENTRIES;

   if (ADDR_W < 21 || ADDR_W > 64) begin : g_bad_aw
      $error("ADDR_W must lie in 21..64");
   end
   if (NUM_VAR < 1) begin : g_bad_nv
      $error("NUM_VAR must be at least 1");
   end
   if ((64'd1 << IDX_W) < 64'(IDX_SPAN)) begin : g_bad_iw
      $error("IDX_W too narrow for the entry count");
   end

   logic [11:0] ctrl_q;
   logic        glob_en, fix_en;
   logic [7:0]  def_type;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (cfg_we && cfg_sel == SEL_CTRL)
         ctrl_q <= cfg_wdata[11:0];
   end

   assign glob_en  = ctrl_q[11];
   assign fix_en   = ctrl_q[10];
   assign def_type = ctrl_q[7:0];

   logic       in_low_mb;
   logic       fixed_use;
   logic [7:0] fix_type;

   assign in_low_mb = (req_addr[ADDR_W-1:LOW_MB_BITS] == '0);

   if (HAS_FIXED) begin : g_fixed
      mtr_fixed_table #(.IDX_W(IDX_W)) u_fix (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && cfg_sel == SEL_FIXED),
         .wr_idx  (cfg_idx),
         .wr_type (cfg_wdata[7:0]),
         .lk_addr (req_addr[LOW_MB_BITS-1:0]),
         .lk_type (fix_type)
      );
      assign fixed_use = fix_en && in_low_mb;
   end else begin : g_nofixed
      assign fix_type  = TYPE_UC;
      assign fixed_use = 1'b0;
   end

   logic [NUM_VAR-1:0]      var_hit;
   logic [NUM_VAR-1:0][7:0] var_type;
   logic                    var_any;
   logic [7:0]              var_merged;

   mtr_var_bank #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (cfg_we && cfg_sel == SEL_BASE),
      .wr_mask  (cfg_we && cfg_sel == SEL_MASK),
      .wr_idx   (cfg_idx),
      .wr_data  (cfg_wdata),
      .lk_addr  (req_addr),
      .hit      (var_hit),
      .hit_type (var_type)
   );

   mtr_merge #(.NUM_VAR(NUM_VAR)) u_merge (
      .hit      (var_hit),
      .hit_type (var_type),
      .any_hit  (var_any),
      .merged   (var_merged)
   );

   logic [7:0] next_type;

   always_comb begin
      if (!glob_en)
         next_type = TYPE_INVALID;
      else if (fixed_use)
         next_type = fix_type;
      else if (var_any)
         next_type = var_merged;
      else
         next_type = def_type;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_type    <= TYPE_INVALID;
         rsp_invalid <= 1'b1;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_type    <= next_type;
            rsp_invalid <= !glob_en;
         end
      end
   end

   // checker-side view of uncacheable hits, built apart from the merge tree
   logic uc_seen;
   always_comb begin
      uc_seen = 1'b0;
      for (int r = 0; r < NUM_VAR; r++)
         if (var_hit[r] && var_type[r] == TYPE_UC) uc_seen = 1'b1;
   end

   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                                  // R10
   AST_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !glob_en |=> rsp_invalid && rsp_type == TYPE_INVALID);        // R9
   AST_FIXED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && glob_en && fixed_use |=> rsp_type == $past(fix_type));        // R4
   AST_DEFAULT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && glob_en && !fixed_use && !var_any |=> rsp_type == $past(def_type)); // R8
   AST_UC_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && glob_en && !fixed_use && uc_seen |=> rsp_type == TYPE_UC);    // R6
endmodule

// File: tb/sim_memtype_resolver.sv
`timescale 1ns/1ps
module sim_memtype_resolver;
   localparam int AW = 24;
   localparam int NV = 4;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [7:0]    rsp_type;
   logic          rsp_invalid;

   always #4 clk = ~clk;

   memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .IDX_W(IW), .HAS_FIXED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_invalid(rsp_invalid)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // model state
   logic [11:0]   m_ctrl = '0;
   logic [7:0]    m_fix [88];
   logic [AW-1:0] m_base [NV];
   logic [AW-1:0] m_mask [NV];

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_type(input logic [AW-1:0] a, output string tag);
      logic [7:0] first_t = 8'h00;
      bit any = 0, differ = 0, uc = 0, wbwt = 1;
      int idx;
      if (!m_ctrl[11]) begin tag = "R9"; return 8'hFF; end
      if (a < 24'h100000 && m_ctrl[10]) begin
         if (a < 24'h80000)      begin idx = int'(a >> 16);                 tag = "R1"; end
         else if (a < 24'hC0000) begin idx = 8 + int'((a - 24'h80000) >> 14);  tag = "R2"; end
         else                    begin idx = 24 + int'((a - 24'hC0000) >> 12); tag = "R3"; end
         return m_fix[idx];
      end
      for (int r = 0; r < NV; r++) begin
         logic [AW-1:0] mk = m_mask[r] & ~24'hFFF;
         if (m_mask[r][11] && ((a & mk) == (m_base[r] & mk))) begin
            if (!any) first_t = m_base[r][7:0];
            else if (m_base[r][7:0] != first_t) differ = 1;
            any = 1;
            if (m_base[r][7:0] == 8'h00) uc = 1;
            if (m_base[r][7:0] != 8'h06 && m_base[r][7:0] != 8'h04) wbwt = 0;
         end
      end
      if (!any) begin tag = (a < 24'h100000) ? "R4 R8" : "R8"; return m_ctrl[7:0]; end
      if (uc) begin tag = "R6"; return 8'h00; end
      if (differ) begin tag = "R7"; return wbwt ? 8'h04 : 8'h00; end
      tag = (a < 24'h100000) ? "R4 R5" : "R5";
      return first_t;
   endfunction

   task automatic wr(input logic [1:0] sel, input int idx, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      case (sel)
         2'd0: m_ctrl = d[11:0];
         2'd1: if (idx < 88) m_fix[idx] = d[7:0];
         2'd2: if (idx < NV) m_base[idx] = d;
         default: if (idx < NV) m_mask[idx] = d;
      endcase
   endtask

   task automatic set_range(input int r, input logic [AW-1:0] base, input logic [AW-1:0] size,
                            input logic [7:0] t, input bit vld);
      wr(2'd2, r, base | AW'(t));
      wr(2'd3, r, (~(size - 1) & ~24'hFFF) | (vld ? 24'h800 : 24'h0));
   endtask

   task automatic lookup(input logic [AW-1:0] a);
      string tag;
      logic [7:0] e;
      @(negedge clk);
      req_valid = 1; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      e = ref_type(a, tag);
      check({tag, " R10"}, {rsp_valid, rsp_invalid, rsp_type}, {1'b1, !m_ctrl[11], e});
   endtask

   task automatic sweep(input int pages);
      for (int p = 0; p < pages; p++)
         lookup(AW'(p) << 12 | AW'((p * 37) & 12'hFFF));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 88; i++) m_fix[i] = 8'h00;
      for (int r = 0; r < NV; r++) begin m_base[r] = '0; m_mask[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: reset state
      check("R11 reset", {rsp_valid, rsp_invalid, rsp_type}, {1'b0, 1'b1, 8'hFF});
      lookup(24'h001234);            // R11 enables clear after reset -> invalid

      // R12: load state while globally disabled
      for (int i = 0; i < 88; i++) wr(2'd1, i, AW'(i ^ 8'h40));
      wr(2'd1, 100, 24'h0000AA);     // R12 out-of-range index ignored
      set_range(0, 24'h000000, 24'h200000, 8'h06, 1);
      set_range(1, 24'h100000, 24'h080000, 8'h04, 1);
      set_range(2, 24'h400000, 24'h400000, 8'h01, 1);
      set_range(3, 24'h600000, 24'h100000, 8'h00, 1);
      wr(2'd2, 9, 24'h000001);       // R12 beyond range bank, ignored
      wr(2'd0, 0, 24'h000005);       // R9 default WP, global enable clear
      lookup(24'h123456);            // R9
      lookup(24'h000100);            // R9

      // global + fixed enabled
      wr(2'd0, 0, 24'h000C05);
      sweep(256);                    // R1 R2 R3 every 4K page of low MB
      lookup(24'h0FFFFF);            // R3 last entry
      sweep(4096);                   // R4 R5 R6 R7 R8 full space

      // fixed enable cleared: low MB falls to variable ranges
      wr(2'd0, 0, 24'h000805);
      sweep(1024);                   // R4

      // reshaped ranges: valid bit dropped, same-type and WB/WC overlaps
      set_range(0, 24'h000000, 24'h200000, 8'h06, 0);  // R5 valid clear
      set_range(1, 24'h100000, 24'h080000, 8'h06, 1);
      set_range(2, 24'h400000, 24'h400000, 8'h06, 1);
      set_range(3, 24'h600000, 24'h100000, 8'h01, 1);  // R7 WB vs WC -> UC
      sweep(4096);

      // R10: write then lookup in the very next cycle
      @(negedge clk);
      cfg_we = 1; cfg_sel = 2'd0; cfg_idx = '0; cfg_wdata = 24'h000C06;
      @(negedge clk);
      cfg_we = 0; m_ctrl = 12'hC06;
      req_valid = 1; req_addr = 24'hF00000;
      @(negedge clk);
      req_valid = 0;
      check("R10 R8 write-then-lookup", {rsp_valid, rsp_invalid, rsp_type}, {1'b1, 1'b0, 8'h06});
      @(negedge clk);
      check("R10 no request no valid", {rsp_valid, 9'h0}, {1'b0, 9'h0});

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule